// File: doc/BRIEF.md
# Preemptive Priority Wormhole Output Arbiter

This block decides, every cycle, which input port of a wormhole-switched mesh router may place a flit on one output link. Each input offers one flit at a time from one of its per-class virtual channels, tagged with a service class and head/tail markers. Four classes are ranked in a fixed order: class 0 (signaling) is the most urgent, then class 1 (real-time stream), class 2 (read-write) and class 3 (bulk block transfer). A more urgent class can slip its flits in between the flits of a less urgent worm that is already under way. Within a class, a worm keeps the output class lane until its tail has left.

Each class keeps a credit count for its downstream buffer. Sending a flit spends one credit, and each pulse on the return wire restores one. A class without credit drops out of arbitration and does not block the other classes. Heads of the same class that compete for a free lane are served round-robin. The accepted flit appears on registered output ports one cycle after the handshake.

Top module: `prio_worm_arb`

## Requirements
- R1: After reset, with no input valid, `in_ready` is all zero and `out_valid` is low, and every class holds `CRED_MAX` credits.
- R2: When several classes have an eligible flit and credit, the lowest class index (0 = most urgent) is the only one granted.
- R3: An eligible flit of a more urgent class is granted even while a less urgent worm is only partly sent. The interrupted worm later continues with its next body flit, which leaves with `out_head` = 0.
- R4: While a class lane is held by input i (head with tail=0 sent, tail not yet sent), head flits of that class from other inputs get no grant. The lane frees on the cycle its tail is accepted.
- R5: Among competing heads of a free class, the search starts at the input after the one whose head last won that class (input 0 after reset), wrapping around.
- R6: A class with zero credits gets no grant while other classes with credit proceed. Each `cred_ret` pulse for the class allows exactly one more flit.
- R7: A flit with head=1 and tail=1 takes and frees the class lane in the same cycle, so the next head of that class is not blocked.
- R8: A flit accepted in a cycle (`in_ready` high) appears the next cycle on `out_valid`, `out_cls`, `out_head`, `out_tail`, `out_src` and `out_data`. If nothing is accepted, `out_valid` is low the next cycle.
- R9: A non-head flit (head=0) of a class whose lane is free is never accepted.
- R10: At most one bit of `in_ready` is high, and only for an input whose `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Flit offered per input |
| in_cls | input | N_IN*CW | Class tag per input, input i at bits [i*CW +: CW] |
| in_head | input | N_IN | Head marker per input |
| in_tail | input | N_IN | Tail marker per input |
| in_data | input | N_IN*FLIT_W | Flit payload per input, input i at bits [i*FLIT_W +: FLIT_W] |
| in_ready | output | N_IN | Grant: flit of that input is taken this cycle |
| cred_ret | input | N_CLS | One credit returned per class per pulse |
| out_valid | output | 1 | Registered flit on the link |
| out_cls | output | CW | Class of the output flit |
| out_head | output | 1 | Head marker of the output flit |
| out_tail | output | 1 | Tail marker of the output flit |
| out_src | output | IW | Input the output flit came from |
| out_data | output | FLIT_W | Output flit payload |

## Verification
Several rules are checked on every cycle by the assertions: the grant is one-hot or empty and lands only on an offering input, each grant is followed by an output flit, an idle cycle gives an idle output, and the credit counters never wrap in either direction. Class ranking, mid-worm preemption with resumption by a body flit, lane holding until the tail, the round-robin order after a worm ends, single-flit packets and credit exhaustion and recovery all depend on a history of several cycles. The directed scenarios in the bench check these by comparing grants and output flits with expected values.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  typedef enum logic [1:0] {
    CLS_SIG  = 2'd0,
    CLS_RT   = 2'd1,
    CLS_RW   = 2'd2,
    CLS_BULK = 2'd3
  } svc_cls_e;

  function automatic int next_idx(input int cur, input int n);
    return (cur + 1 == n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/arb_rr.sv
module arb_rr #(
  parameter int N  = 4,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic          any
);
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
  parameter int MAX = 4,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic dec,
  input  logic inc,
  output logic avail
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= W'(MAX);
    else     cnt <= cnt + W'(inc) - W'(dec);
  end

  assign avail = (cnt != '0);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |-> (cnt != W'(MAX)));
endmodule

// File: rtl/prio_worm_arb.sv
module prio_worm_arb
  import pwa_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_CLS    = 4,
  parameter int FLIT_W   = 16,
  parameter int CRED_MAX = 4,
  parameter int CW       = $clog2(N_CLS),
  parameter int IW       = $clog2(N_IN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [N_IN*CW-1:0]       in_cls,
  input  logic [N_IN-1:0]          in_head,
  input  logic [N_IN-1:0]          in_tail,
  input  logic [N_IN*FLIT_W-1:0]   in_data,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_CLS-1:0]         cred_ret,
  output logic                     out_valid,
  output logic [CW-1:0]            out_cls,
  output logic                     out_head,
  output logic                     out_tail,
  output logic [IW-1:0]            out_src,
  output logic [FLIT_W-1:0]        out_data
);
  logic [N_CLS-1:0] lock_q;
  logic [IW-1:0]    owner_q [N_CLS];
  logic [IW-1:0]    ptr_q   [N_CLS];
  logic [N_IN-1:0]  cand    [N_CLS];
  logic [N_IN-1:0]  rr_gnt  [N_CLS];
  logic [N_CLS-1:0] rr_any, has_cred, sent_c;
  logic             win_ok;
  logic [CW-1:0]    win_c;
  logic [IW-1:0]    win_src;
  logic [N_IN-1:0]  gnt;

  // candidate inputs per class: lane owner's body/tail, or heads on a free lane
  always_comb begin
    for (int c = 0; c < N_CLS; c++) begin
      for (int i = 0; i < N_IN; i++) begin
        logic vi;
        vi = in_valid[i] && (in_cls[i*CW +: CW] == CW'(c));
        if (lock_q[c]) cand[c][i] = vi && (owner_q[c] == IW'(i)) && !in_head[i];
        else           cand[c][i] = vi && in_head[i];
      end
    end
  end

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    arb_rr #(.N(N_IN), .PW(IW)) u_rr (
      .req (cand[c]),
      .ptr (ptr_q[c]),
      .gnt (rr_gnt[c]),
      .any (rr_any[c])
    );
    credit_ctr #(.MAX(CRED_MAX)) u_cred (
      .clk   (clk),
      .rst   (rst),
      .dec   (sent_c[c]),
      .inc   (cred_ret[c]),
      .avail (has_cred[c])
    );
  end

  // fixed class ranking: lowest index with a candidate and credit wins
  always_comb begin
    win_ok = 1'b0;
    win_c  = '0;
    for (int c = N_CLS - 1; c >= 0; c--) begin
      if (rr_any[c] && has_cred[c]) begin
        win_ok = 1'b1;
        win_c  = CW'(c);
      end
    end
    gnt = win_ok ? rr_gnt[win_c] : '0;
    sent_c = '0;
    if (win_ok) sent_c[win_c] = 1'b1;
    win_src = '0;
    for (int i = 0; i < N_IN; i++)
      if (gnt[i]) win_src = IW'(i);
  end

  assign in_ready = gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= '0;
      out_valid <= 1'b0;
      out_cls   <= '0;
      out_head  <= 1'b0;
      out_tail  <= 1'b0;
      out_src   <= '0;
      out_data  <= '0;
      for (int c = 0; c < N_CLS; c++) begin
        owner_q[c] <= '0;
        ptr_q[c]   <= '0;
      end
    end else begin
      out_valid <= win_ok;
      if (win_ok) begin
        out_cls  <= win_c;
        out_head <= in_head[win_src];
        out_tail <= in_tail[win_src];
        out_src  <= win_src;
        out_data <= in_data[win_src*FLIT_W +: FLIT_W];
        if (in_head[win_src]) begin
          ptr_q[win_c] <= IW'(next_idx(int'(win_src), N_IN));
          if (!in_tail[win_src]) begin
            lock_q[win_c]  <= 1'b1;
            owner_q[win_c] <= win_src;
          end
        end
        if (in_tail[win_src]) lock_q[win_c] <= 1'b0;
      end
    end
  end

  // R10
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  // R10
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);

  // R8
  grant_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |=> out_valid);

  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(|in_ready) |=> !out_valid);
endmodule

// File: tb/prio_worm_arb_tb.sv
module prio_worm_arb_tb;
  import pwa_pkg::*;

  localparam int N_IN = 4, N_CLS = 4, FW = 16, CM = 4, CW = 2, IW = 2;

  logic clk = 1'b0;
  logic rst;
  logic [N_IN-1:0]    in_valid, in_head, in_tail, in_ready;
  logic [N_IN*CW-1:0] in_cls;
  logic [N_IN*FW-1:0] in_data;
  logic [N_CLS-1:0]   cred_ret;
  logic               out_valid, out_head, out_tail;
  logic [CW-1:0]      out_cls;
  logic [IW-1:0]      out_src;
  logic [FW-1:0]      out_data;

  int  n_run = 0, n_fail = 0;
  bit  auto_ret = 1'b1;
  logic [N_CLS-1:0] man_ret = '0;
  logic [N_IN-1:0]  rdy_s;
  logic [7:0]       serial = 8'd0;

  always #5 clk = ~clk;

  prio_worm_arb #(.N_IN(N_IN), .N_CLS(N_CLS), .FLIT_W(FW), .CRED_MAX(CM)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_head(in_head),
    .in_tail(in_tail), .in_data(in_data), .in_ready(in_ready), .cred_ret(cred_ret),
    .out_valid(out_valid), .out_cls(out_cls), .out_head(out_head), .out_tail(out_tail),
    .out_src(out_src), .out_data(out_data)
  );

  function automatic logic [FW-1:0] tag(input int c, input int i, input logic [7:0] s);
    return FW'((c << 12) | (i << 8) | int'(s));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    in_valid = '0; in_head = '0; in_tail = '0; in_cls = '0; in_data = '0;
    man_ret = '0;
  endtask

  task automatic put(input int i, input int c, input bit h, input bit t);
    in_valid[i] = 1'b1;
    in_cls[i*CW +: CW] = CW'(c);
    in_head[i] = h;
    in_tail[i] = t;
    in_data[i*FW +: FW] = tag(c, i, serial);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic cycle();
    if (auto_ret) cred_ret = out_valid ? (N_CLS'(1) << out_cls) : '0;
    else          cred_ret = man_ret;
    #1 rdy_s = in_ready;
    @(negedge clk);
    serial = serial + 8'd1;
  endtask

  task automatic do_reset();
    clr();
    cred_ret = '0;
    auto_ret = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk_out(input string req, input int c, input int src, input bit h,
                         input bit t, input logic [FW-1:0] d);
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    chk(out_cls == CW'(c) && out_src == IW'(src), req, "out_cls/src",
        int'({out_cls, out_src}), (c << IW) | src);
    chk(out_head == h && out_tail == t, req, "head/tail", int'({out_head, out_tail}),
        int'({h, t}));
    chk(out_data == d, req, "out_data", int'(out_data), int'(d));
  endtask

  task automatic t_reset();
    logic [FW-1:0] d;
    do_reset();
    cycle();
    chk(rdy_s == 4'b0000, "R1", "in_ready idle", int'(rdy_s), 0);
    chk(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);
    // two classes at once: class 1 beats class 3 (R2), output next cycle (R8)
    clr(); put(0, CLS_BULK, 1, 1); put(1, CLS_RT, 1, 1); d = tag(CLS_RT, 1, serial);
    cycle();
    chk(rdy_s == 4'b0010, "R2", "class rank grant", int'(rdy_s), 4'b0010);
    chk_out("R8", CLS_RT, 1, 1, 1, d);
    clr(); cycle();
    chk(out_valid == 1'b0, "R8", "idle after nothing taken", int'(out_valid), 0);
  endtask

  task automatic t_preempt();
    logic [FW-1:0] d;
    do_reset();
    clr(); put(0, CLS_BULK, 1, 0); cycle();
    chk(rdy_s == 4'b0001, "R3", "bulk head taken", int'(rdy_s), 1);
    clr(); put(0, CLS_BULK, 0, 0); put(2, CLS_SIG, 1, 1); d = tag(CLS_SIG, 2, serial);
    cycle();
    chk(rdy_s == 4'b0100, "R3", "signal cuts into worm", int'(rdy_s), 4'b0100);
    chk_out("R3", CLS_SIG, 2, 1, 1, d);
    clr(); put(0, CLS_BULK, 0, 0); d = tag(CLS_BULK, 0, serial); cycle();
    chk(rdy_s == 4'b0001, "R3", "worm resumes", int'(rdy_s), 1);
    chk_out("R3", CLS_BULK, 0, 0, 0, d);
    clr(); put(0, CLS_BULK, 0, 1); d = tag(CLS_BULK, 0, serial); cycle();
    chk_out("R3", CLS_BULK, 0, 0, 1, d);
  endtask

  task automatic t_lock_rr();
    logic [FW-1:0] d;
    do_reset();
    clr(); put(1, CLS_RW, 1, 0); put(3, CLS_RW, 1, 0); cycle();
    chk(rdy_s == 4'b0010, "R5", "first search from input 0", int'(rdy_s), 4'b0010);
    clr(); put(1, CLS_RW, 0, 0); put(3, CLS_RW, 1, 0); cycle();
    chk(rdy_s == 4'b0010, "R4", "lane held by body", int'(rdy_s), 4'b0010);
    clr(); put(3, CLS_RW, 1, 0); cycle();
    chk(rdy_s == 4'b0000, "R4", "other head refused", int'(rdy_s), 0);
    clr(); put(1, CLS_RW, 0, 1); put(3, CLS_RW, 1, 0); cycle();
    chk(rdy_s == 4'b0010, "R4", "tail of owner taken", int'(rdy_s), 4'b0010);
    clr(); put(1, CLS_RW, 1, 1); put(3, CLS_RW, 1, 1); d = tag(CLS_RW, 3, serial);
    cycle();
    chk(rdy_s == 4'b1000, "R5", "next search after input 1", int'(rdy_s), 4'b1000);
    chk_out("R5", CLS_RW, 3, 1, 1, d);
  endtask

  task automatic t_single();
    do_reset();
    clr(); put(0, CLS_RT, 1, 1); cycle();
    chk(rdy_s == 4'b0001, "R7", "single-flit taken", int'(rdy_s), 1);
    clr(); put(2, CLS_RT, 1, 0); cycle();
    chk(rdy_s == 4'b0100, "R7", "lane free after one flit", int'(rdy_s), 4'b0100);
  endtask

  task automatic t_orphan_body();
    do_reset();
    clr(); put(0, CLS_RW, 0, 0); cycle();
    chk(rdy_s == 4'b0000, "R9", "body on free lane refused", int'(rdy_s), 0);
    clr(); cycle();
    chk(out_valid == 1'b0, "R9", "no output from refused body", int'(out_valid), 0);
  endtask

  task automatic t_credit();
    do_reset();
    auto_ret = 1'b0;
    for (int k = 0; k < CM; k++) begin
      clr(); put(0, CLS_RW, 1, 1); cycle();
      chk(rdy_s == 4'b0001, "R6", "send within credit", int'(rdy_s), 1);
    end
    clr(); put(0, CLS_RW, 1, 1); put(1, CLS_BULK, 1, 1); cycle();
    chk(rdy_s == 4'b0010, "R6", "empty class skipped", int'(rdy_s), 4'b0010);
    clr(); put(0, CLS_RW, 1, 1); man_ret[CLS_RW] = 1'b1; cycle();
    chk(rdy_s == 4'b0000, "R6", "still empty on return cycle", int'(rdy_s), 0);
    clr(); put(0, CLS_RW, 1, 1); cycle();
    chk(rdy_s == 4'b0001, "R6", "one credit back", int'(rdy_s), 1);
    clr(); put(0, CLS_RW, 1, 1); cycle();
    chk(rdy_s == 4'b0000, "R6", "only one flit allowed", int'(rdy_s), 0);
    auto_ret = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clr();
    cred_ret = '0;
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_preempt();
    t_lock_rr();
    t_single();
    t_orphan_body();
    t_credit();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule